// File: doc/BRIEF.md
# Page-boundary access probe splitter

This block sits between a requester that wants to check a memory access in advance and a probe port that answers with a fault or a clean result. A request carries a start address, a size coded as a base-two logarithm, a load/store flag and a privilege index. The block finds out how many bytes lie between the start address and the next page boundary. If the whole access fits inside that span, one probe goes out. If it does not, two probes go out in turn, one for each side of the boundary.

Each probe is offered with a valid/ready handshake, and then the block waits for a single-cycle response from downstream. When the last response arrives, or a fault arrives earlier, the block gives one completion pulse. On a fault it also reports the address of the probe that failed. The block takes one request at a time.

Top module: `page_probe_split`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `prb_valid` is 0 and `done` is 0.
- R2: The room left in the page is PAGE_BYTES minus (address mod PAGE_BYTES), and the access size is 2 to the power `req_log2sz` (at most one page). When the size is not larger than the room, exactly one probe is issued, at the request address, with `prb_len` equal to the size.
- R3: When the size is larger than the room, the first probe is at the request address and its `prb_len` equals the room.
- R4: In the split case, the second probe is at the request address plus the room and its length is the size minus the room. It is issued after the first probe has been answered without a fault.
- R5: Every probe carries the `req_store` value and the `req_idx` value of the request it came from.
- R6: `prb_valid` rises in the cycle after a request is accepted and stays high, with stable address and length, until `prb_ready` is seen. It is low while the block waits for a response.
- R7: A fault response ends the request at once, and no further probe is issued. `done` and `fault` are then both 1, and `fault_addr` gives the address of the probe that faulted.
- R8: `done` is 1 for exactly one cycle, the cycle after the final response. `fault` is 0 when no probe faulted.
- R9: `req_ready` is 0 from acceptance until completion. A request offered in that window has no effect on the probes in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_addr | input | ADDR_W | Start address of the access |
| req_log2sz | input | SZ_W | Base-two logarithm of the access size in bytes |
| req_store | input | 1 | 1 for store, 0 for load |
| req_idx | input | IDX_W | Privilege / translation index |
| prb_valid | output | 1 | Probe offered downstream |
| prb_ready | input | 1 | Downstream takes the probe |
| prb_addr | output | ADDR_W | Probe start address |
| prb_len | output | LEN_W | Probe length in bytes |
| prb_store | output | 1 | Probe load/store flag |
| prb_idx | output | IDX_W | Probe privilege index |
| rsp_valid | input | 1 | Response for the outstanding probe |
| rsp_fault | input | 1 | Response reports a fault |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | With `done`: the request faulted |
| fault_addr | output | ADDR_W | With `done` and `fault`: address of the faulting probe |

## Verification
The first probe appears one cycle after the accepting edge. A probe leaves the port one cycle after the edge where `prb_ready` is seen. Each response turns, one cycle later, into either the next probe or the `done` pulse, so every result is due one edge after the stimulus that causes it. The bench drives and samples on the falling edge. After each rising edge it checks the value that edge should have produced, and it checks again one cycle later to confirm that `done` has dropped. A sweep over every in-page offset and every legal size on a 64-byte page covers both the single-probe and the split cases, with faults placed on the first and on the second probe and with several stall lengths on `prb_ready`.

// File: rtl/page_probe_split.sv
module page_probe_split #(
  parameter int ADDR_W     = 48,
  parameter int PAGE_BYTES = 4096,
  parameter int IDX_W      = 4,
  localparam int PG_LOG2   = $clog2(PAGE_BYTES),
  localparam int LEN_W     = PG_LOG2 + 1,
  localparam int SZ_W      = $clog2(PG_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_log2sz,
  input  logic              req_store,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              prb_valid,
  input  logic              prb_ready,
  output logic [ADDR_W-1:0] prb_addr,
  output logic [LEN_W-1:0]  prb_len,
  output logic              prb_store,
  output logic [IDX_W-1:0]  prb_idx,
  input  logic              rsp_valid,
  input  logic              rsp_fault,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [ADDR_W-1:0] cur_addr, faddr_q;
  logic [LEN_W-1:0]  cur_len, nxt_len;
  logic              two, store_q, done_q, fault_q;
  logic [IDX_W-1:0]  idx_q;

  wire [LEN_W-1:0] room  = LEN_W'(PAGE_BYTES) - {1'b0, req_addr[PG_LOG2-1:0]};
  wire [LEN_W-1:0] size  = LEN_W'(1) << req_log2sz;
  wire             split = size > room;

  assign req_ready  = (st == S_IDLE);
  assign prb_valid  = (st == S_ISSUE);
  assign prb_addr   = cur_addr;
  assign prb_len    = cur_len;
  assign prb_store  = store_q;
  assign prb_idx    = idx_q;
  assign done       = done_q;
  assign fault      = done_q & fault_q;
  assign fault_addr = faddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      cur_len  <= '0;
      nxt_len  <= '0;
      two      <= 1'b0;
      store_q  <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      faddr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_len  <= split ? room : size;
          nxt_len  <= size - room;
          two      <= split;
          store_q  <= req_store;
          idx_q    <= req_idx;
          st       <= S_ISSUE;
        end
        S_ISSUE: if (prb_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_fault || !two) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            fault_q <= rsp_fault;
            faddr_q <= cur_addr;
          end else begin
            cur_addr <= cur_addr + ADDR_W'(cur_len);
            cur_len  <= nxt_len;
            two      <= 1'b0;
            st       <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_probe_split_chk.sv
module page_probe_split_chk #(
  parameter int ADDR_W     = 48,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_LOG2   = $clog2(PAGE_BYTES),
  localparam int LEN_W     = PG_LOG2 + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              prb_valid,
  input logic              prb_ready,
  input logic [ADDR_W-1:0] prb_addr,
  input logic [LEN_W-1:0]  prb_len,
  input logic              done,
  input logic              fault
);

  wire [LEN_W:0] end_off = {2'b00, prb_addr[PG_LOG2-1:0]} + {1'b0, prb_len};

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid && !prb_ready |=> prb_valid && $stable(prb_addr) && $stable(prb_len));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && prb_valid));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> (prb_len != '0) && (prb_len <= LEN_W'(PAGE_BYTES)));

  a_r3_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> end_off <= (LEN_W+1)'(PAGE_BYTES));

  a_r6_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> prb_valid);

endmodule

bind page_probe_split page_probe_split_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .prb_valid(prb_valid),
  .prb_ready(prb_ready), .prb_addr(prb_addr), .prb_len(prb_len),
  .done(done), .fault(fault)
);

// File: tb/test_page_probe_split.sv
module test_page_probe_split;
  localparam int AW = 12, PG = 64, IW = 3, LW = 7, SW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, prb_ready = 0, rsp_valid = 0, rsp_fault = 0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_log2sz = '0;
  logic [IW-1:0] req_idx = '0;
  logic req_ready, prb_valid, prb_store, done, fault;
  logic [AW-1:0] prb_addr, fault_addr;
  logic [LW-1:0] prb_len;
  logic [IW-1:0] prb_idx;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  page_probe_split #(.ADDR_W(AW), .PAGE_BYTES(PG), .IDX_W(IW)) i_page_probe_split (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_log2sz(req_log2sz), .req_store(req_store), .req_idx(req_idx),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr), .prb_len(prb_len),
    .prb_store(prb_store), .prb_idx(prb_idx), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .done(done), .fault(fault), .fault_addr(fault_addr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int addr, int lg, bit st, int idx, int fmode, int dly);
    int size = 1 << lg;
    int room = PG - (addr % PG);
    bit split = size > room;
    int n = split ? 2 : 1;
    @(negedge clk);
    chk("R9 ready before request", req_ready, 1);
    req_valid = 1; req_addr = AW'(addr); req_log2sz = SW'(lg); req_store = st; req_idx = IW'(idx);
    @(negedge clk);
    req_valid = 0; req_addr = '1; req_log2sz = '0; req_store = ~st; req_idx = ~IW'(idx);
    for (int p = 0; p < n; p++) begin
      int paddr = p == 0 ? addr : (addr + room) % (1 << AW);
      int plen  = p == 0 ? (split ? room : size) : size - room;
      bit flt   = (fmode == p + 1);
      chk("R6 probe valid", prb_valid, 1);
      chk(p == 0 ? (split ? "R3 first addr" : "R2 single addr") : "R4 second addr", prb_addr, paddr);
      chk(p == 0 ? (split ? "R3 first len" : "R2 single len") : "R4 second len", prb_len, plen);
      chk("R5 store flag", prb_store, st);
      chk("R5 index", prb_idx, idx);
      chk("R8 no early done", done, 0);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R6 held valid", prb_valid, 1);
        chk("R6 held addr", prb_addr, paddr);
      end
      prb_ready = 1;
      @(negedge clk);
      prb_ready = 0;
      chk("R6 low while waiting", prb_valid, 0);
      chk("R9 busy not ready", req_ready, 0);
      req_valid = 1; req_addr = AW'(addr + 5); req_log2sz = SW'(lg);
      @(negedge clk);
      chk("R9 still not ready", req_ready, 0);
      req_valid = 0;
      rsp_valid = 1; rsp_fault = flt;
      @(negedge clk);
      rsp_valid = 0; rsp_fault = 0;
      if (flt || p == n - 1) begin
        chk("R8 done pulse", done, 1);
        chk(flt ? "R7 fault flag" : "R8 no fault", fault, flt);
        if (flt) chk("R7 fault addr", fault_addr, paddr);
        chk("R7 no further probe", prb_valid, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 probe idle", prb_valid, 0);
    chk("R1 done idle", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after release", req_ready, 1);
    for (int lg = 0; lg <= 6; lg++)
      for (int off = 0; off < PG; off++) begin
        int k = (off + lg) % 60 + 1;
        run(k * PG + off, lg, off[0], (off >> 1) % 8, (off + lg) % 5 == 0 ? 1 : ((off + lg) % 5 == 1 ? 2 : 0), off % 3);
      end
    run(PG + 63, 6, 1, 5, 2, 0);
    run(PG + 0, 6, 0, 2, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule